// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block supervises software by means of a 7-bit down-counter. A tick derived from the peripheral clock decrements the counter. The tick is a fixed divide followed by a power-of-two divide that software selects. Software keeps the system alive by writing a fresh count into the control register. If it waits too long, the counter drops from 0x40 to 0x3F and the block requests a CPU reset. If it refreshes too early, while the counter is still above a programmed window value, the block also requests a reset. Software can therefore only refresh inside a window that opens at the window value and closes at 0x40.

An activate bit starts supervision, and no register write can clear it again. An early-warning flag marks the last tick before timeout. Software clears the flag, and the flag can drive an interrupt line. A debug-halt input, qualified by a debug freeze enable, stops the timebase and the counter while a debugger holds the CPU. The register port is a plain write strobe with an address and two byte lanes, plus a combinational read-back of the addressed register.

Top module: `win_watchdog`

## Requirements
- R1: After system reset, address 0 reads 0x007F (count 0x7F, inactive), address 1 reads 0x007F (window 0x7F, prescaler select 0, early-warning enable 0), address 2 reads 0, and `rst_req` and `ewi_irq` are low.
- R2: Address 0 is the control register, with count in bits [6:0] and activate in bit 7. A write with byte lane 0 enabled loads the count and restarts the timebase. The counter only decrements while the watchdog is active.
- R3: The tick period is FIXED_DIV × 2^sel clock cycles, where sel is bits [9:8] of address 1. The first decrement after a control write comes one full period after that write.
- R4: An active counter that decrements from 0x40 to 0x3F raises a reset request. From a load of 0x7F this takes exactly 64 ticks.
- R5: Address 1 is the configuration register. Byte lane 0 writes the window in bits [6:0]. Byte lane 1 writes the select in bits [9:8] and the early-warning enable in bit 10. A field whose lane is not enabled keeps its value.
- R6: A control write that arrives while the watchdog is already active and the count is above the window raises a reset request. The new count is loaded anyway. A count equal to the window is accepted.
- R7: Writing activate = 0 never clears an active watchdog. Only system reset does.
- R8: The early-warning flag (address 2, bit 0) sets when an active counter decrements from 0x41 to 0x40. A lane-0 write of 0 to bit 0 clears it, and writing 1 has no effect. `ewi_irq` is high while both the flag and its enable are set.
- R9: While `dbg_halt` and `dbg_freeze_en` are both high, the timebase and the counter hold. `dbg_halt` alone has no effect.
- R10: `rst_req` is a one-cycle pulse, registered one cycle after the event. It fires at most once between system resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address (0 control, 1 configuration, 2 status) |
| bus_be | input | 2 | Byte-lane enables for the write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Combinational read of the addressed register |
| dbg_halt | input | 1 | CPU halted by a debugger |
| dbg_freeze_en | input | 1 | Lets `dbg_halt` freeze the watchdog |
| rst_req | output | 1 | One-cycle CPU reset request |
| ewi_irq | output | 1 | Early-warning interrupt |

## Verification
The bench measures the exact tick count from a 0x7F load to the reset pulse at two prescaler settings. A design that fires at zero, or one tick early or late, shows up as a different cycle count. It refreshes exactly at the window value and one step above it, which separates a correct strict comparison from an off-by-one. It also writes activate = 0 after activation, writes single byte lanes of the configuration register, and writes 1 versus 0 to the status flag, catching a watchdog that can be disabled, lanes that leak into each other, and a flag that clears on any write. Random phases compare every cycle against a bench model, with freeze toggling and a bench that stays silent after a first timeout. These catch a counter that creeps while frozen and a reset request that repeats.

// File: rtl/wwdg_pkg.sv
// Shared constants and address map for the windowed watchdog.
// Assumes a 7-bit counter whose timeout is the clearing of its top bit.
package wwdg_pkg;
    localparam int DATA_W = 16;
    localparam int CNT_W  = 7;

    localparam logic [CNT_W-1:0] CNT_RESET = 7'h7F;
    localparam logic [CNT_W-1:0] CNT_LAST  = 7'h40;  // last value before timeout
    localparam logic [CNT_W-1:0] CNT_WARN  = 7'h41;  // decrement from here sets warning

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_CFG  = 2'd1,
        ADDR_STAT = 2'd2,
        ADDR_NONE = 2'd3
    } wwdg_addr_e;
endpackage

// File: rtl/wwdg_prescaler.sv
// Timebase: emits a one-cycle tick every FIXED_DIV << sel cycles.
// Assumes FIXED_DIV >= 2 and PSC_W >= 1; restart clears the phase, freeze holds it.
module wwdg_prescaler #(
    parameter int FIXED_DIV = 4096,
    parameter int PSC_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             freeze,
    input  logic [PSC_W-1:0] sel,
    output logic             tick
);
    localparam int PW = $clog2(FIXED_DIV) + (1 << PSC_W) - 1;
    localparam logic [PW:0]   BASE = (PW+1)'(FIXED_DIV);
    localparam logic [PW-1:0] ONE  = {{(PW-1){1'b0}}, 1'b1};

    logic [PW-1:0] phase_q;
    logic [PW:0]   span;
    logic [PW-1:0] limit;

    // Purpose: terminal phase value for the selected divide.
    always_comb begin
        span  = BASE << sel;
        limit = span[PW-1:0] - ONE;
    end

    assign tick = !freeze && (phase_q >= limit);

    // Purpose: advance the phase counter, wrapping at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (restart) begin
            phase_q <= '0;
        end else if (freeze) begin
            phase_q <= phase_q;
        end else if (tick) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + ONE;
        end
    end
endmodule

// File: rtl/wwdg_counter.sv
// Down-counter with activate latch, timeout and early-refresh detection.
// Assumes tick is a one-cycle strobe; a load in the same cycle overrides the tick.
module wwdg_counter
    import wwdg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             load_act,
    input  logic             tick,
    input  logic [CNT_W-1:0] window,
    output logic [CNT_W-1:0] count,
    output logic             active,
    output logic             warn_hit,
    output logic             rst_req
);
    logic [CNT_W-1:0] cnt_q;
    logic             act_q;
    logic             done_q;
    logic             req_q;
    logic             timeout;
    logic             early;

    // Purpose: classify the events of this cycle.
    always_comb begin
        timeout  = act_q && tick && !load && (cnt_q == CNT_LAST);
        early    = act_q && load && (cnt_q > window);
        warn_hit = act_q && tick && !load && (cnt_q == CNT_WARN);
    end

    // Purpose: load on refresh, otherwise decrement on active ticks.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= CNT_RESET;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && act_q) begin
            cnt_q <= cnt_q - 7'd1;
        end
    end

    // Purpose: sticky activate bit, set only by a control write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= 1'b0;
        end else begin
            act_q <= act_q | (load & load_act);
        end
    end

    // Purpose: one reset pulse per system reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            req_q  <= (timeout | early) & ~done_q;
            done_q <= done_q | timeout | early;
        end
    end

    assign count   = cnt_q;
    assign active  = act_q;
    assign rst_req = req_q;
endmodule

// File: rtl/wwdg_cfg.sv
// Configuration fields per byte lane, plus the early-warning status flag.
// Assumes set of the flag wins over a clear in the same cycle.
module wwdg_cfg
    import wwdg_pkg::*;
#(
    parameter int PSC_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_be,
    input  logic [CNT_W-1:0] wd_window,
    input  logic [PSC_W-1:0] wd_sel,
    input  logic             wd_ewe,
    input  logic             flag_clr,
    input  logic             warn_hit,
    output logic [CNT_W-1:0] window,
    output logic [PSC_W-1:0] sel,
    output logic             ewi_en,
    output logic             flag
);
    // Purpose: window field on lane 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            window <= CNT_RESET;
        end else if (cfg_we && cfg_be[0]) begin
            window <= wd_window;
        end
    end

    // Purpose: prescaler select and interrupt enable on lane 1.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel    <= '0;
            ewi_en <= 1'b0;
        end else if (cfg_we && cfg_be[1]) begin
            sel    <= wd_sel;
            ewi_en <= wd_ewe;
        end
    end

    // Purpose: early-warning flag, set by hardware, cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (warn_hit) begin
            flag <= 1'b1;
        end else if (flag_clr) begin
            flag <= 1'b0;
        end
    end
endmodule

// File: rtl/win_watchdog.sv
// Top of the windowed watchdog: register decode, timebase, counter, read-back.
// Assumes one register write per cycle and a synchronous active-low reset.
module win_watchdog
    import wwdg_pkg::*;
#(
    parameter int FIXED_DIV = 4096,
    parameter int PSC_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [1:0]        bus_addr,
    input  logic [1:0]        bus_be,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              dbg_halt,
    input  logic              dbg_freeze_en,
    output logic              rst_req,
    output logic              ewi_irq
);
    localparam int SEL_LSB = 8;
    localparam int EWE_BIT = SEL_LSB + PSC_W;
    localparam int CFG_PAD = DATA_W - EWE_BIT - 1;

    logic             load_w;
    logic             cfg_w;
    logic             clr_w;
    logic             freeze_w;
    logic             tick_w;
    logic             act_w;
    logic             warn_w;
    logic             flag_w;
    logic             ewe_w;
    logic [CNT_W-1:0] cnt_w;
    logic [CNT_W-1:0] win_w;
    logic [PSC_W-1:0] sel_w;
    logic             unused_wdata;

    // Purpose: decode register writes and the debug freeze.
    always_comb begin
        load_w   = bus_we && (bus_addr == ADDR_CTRL) && bus_be[0];
        cfg_w    = bus_we && (bus_addr == ADDR_CFG);
        clr_w    = bus_we && (bus_addr == ADDR_STAT) && bus_be[0] && !bus_wdata[0];
        freeze_w = dbg_halt && dbg_freeze_en;
    end

    assign unused_wdata = ^bus_wdata[DATA_W-1:EWE_BIT+1];

    wwdg_prescaler #(.FIXED_DIV(FIXED_DIV), .PSC_W(PSC_W)) u_psc (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (load_w),
        .freeze  (freeze_w),
        .sel     (sel_w),
        .tick    (tick_w)
    );

    wwdg_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load_w),
        .load_val (bus_wdata[CNT_W-1:0]),
        .load_act (bus_wdata[CNT_W]),
        .tick     (tick_w),
        .window   (win_w),
        .count    (cnt_w),
        .active   (act_w),
        .warn_hit (warn_w),
        .rst_req  (rst_req)
    );

    wwdg_cfg #(.PSC_W(PSC_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_w),
        .cfg_be    (bus_be),
        .wd_window (bus_wdata[CNT_W-1:0]),
        .wd_sel    (bus_wdata[EWE_BIT-1:SEL_LSB]),
        .wd_ewe    (bus_wdata[EWE_BIT]),
        .flag_clr  (clr_w),
        .warn_hit  (warn_w),
        .window    (win_w),
        .sel       (sel_w),
        .ewi_en    (ewe_w),
        .flag      (flag_w)
    );

    assign ewi_irq = flag_w & ewe_w;

    // Purpose: combinational read-back of the addressed register.
    always_comb begin
        case (bus_addr)
            ADDR_CTRL: bus_rdata = {{(DATA_W-CNT_W-1){1'b0}}, act_w, cnt_w};
            ADDR_CFG:  bus_rdata = {{CFG_PAD{1'b0}}, ewe_w, sel_w, 1'b0, win_w};
            ADDR_STAT: bus_rdata = {{(DATA_W-1){1'b0}}, flag_w};
            default:   bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/wwdg_chk.sv
// Property checker for the windowed watchdog, bound to the top module.
// Assumes the bind connects the top's internal nets listed below.
module wwdg_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       active,
    input logic [6:0] count,
    input logic       tick,
    input logic       freeze,
    input logic       load,
    input logic       rst_req,
    input logic       flag
);
    // R7
    act_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        active |=> active);

    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    // R4
    rst_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |-> $past(active));

    // R9
    freeze_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze && !load) |=> $stable(count));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !load) |=> $stable(count));

    // R3
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

    // R8
    warn_point_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ($past(count) == 7'h41 && count == 7'h40));
endmodule

bind win_watchdog wwdg_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .active  (act_w),
    .count   (cnt_w),
    .tick    (tick_w),
    .freeze  (freeze_w),
    .load    (load_w),
    .rst_req (rst_req),
    .flag    (flag_w)
);

// File: tb/win_watchdog_bench.sv
`timescale 1ns/100ps
module win_watchdog_bench;
    localparam int FD = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [1:0]  bus_be = 2'd0;
    logic [15:0] bus_wdata = 16'd0;
    logic [15:0] bus_rdata;
    logic        dbg_halt = 1'b0;
    logic        dbg_freeze_en = 1'b0;
    logic        rst_req;
    logic        ewi_irq;

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    bit started = 1'b0;

    always #2.5 clk = ~clk;

    win_watchdog #(.FIXED_DIV(FD), .PSC_W(2)) u_win_watchdog (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dbg_halt(dbg_halt), .dbg_freeze_en(dbg_freeze_en),
        .rst_req(rst_req), .ewi_irq(ewi_irq)
    );

    // Reference model built from the requirements.
    int unsigned m_pc;
    logic [6:0]  m_cnt, m_win;
    logic [1:0]  m_sel;
    logic        m_act, m_done, m_req, m_flg, m_ewe;
    string       m_tag = "R4";

    always @(posedge clk) begin
        logic frz, tk, cw, tmo, prem;
        int unsigned lim;
        if (!rst_n) begin
            m_pc <= 0; m_cnt <= 7'h7F; m_win <= 7'h7F; m_sel <= 2'd0;
            m_act <= 1'b0; m_done <= 1'b0; m_req <= 1'b0; m_flg <= 1'b0; m_ewe <= 1'b0;
        end else begin
            frz  = dbg_halt && dbg_freeze_en;
            lim  = (FD << m_sel) - 1;
            tk   = !frz && (m_pc >= lim);
            cw   = bus_we && bus_addr == 2'd0 && bus_be[0];
            tmo  = m_act && tk && !cw && m_cnt == 7'h40;
            prem = m_act && cw && m_cnt > m_win;
            m_req  <= (tmo || prem) && !m_done;
            m_done <= m_done || tmo || prem;
            if (prem) m_tag <= "R6"; else if (tmo) m_tag <= "R4";
            m_pc <= cw ? 0 : (frz ? m_pc : (tk ? 0 : m_pc + 1));
            if (cw) m_cnt <= bus_wdata[6:0];
            else if (tk && m_act) m_cnt <= m_cnt - 7'd1;
            m_act <= m_act || (cw && bus_wdata[7]);
            if (m_act && tk && !cw && m_cnt == 7'h41) m_flg <= 1'b1;
            else if (bus_we && bus_addr == 2'd2 && bus_be[0] && !bus_wdata[0]) m_flg <= 1'b0;
            if (bus_we && bus_addr == 2'd1 && bus_be[0]) m_win <= bus_wdata[6:0];
            if (bus_we && bus_addr == 2'd1 && bus_be[1]) begin
                m_sel <= bus_wdata[9:8];
                m_ewe <= bus_wdata[10];
            end
        end
    end

    function automatic logic [15:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return {8'h00, m_act, m_cnt};
            2'd1:    return {5'b0, m_ewe, m_sel, 1'b0, m_win};
            2'd2:    return {15'b0, m_flg};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string rd_tag(input logic [1:0] a);
        case (a)
            2'd0:    return "R2";
            2'd1:    return "R5";
            default: return "R8";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Cycle-by-cycle comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (started) begin
            check(rst_req === m_req, m_tag, "rst_req", {31'b0, rst_req}, {31'b0, m_req});
            check(ewi_irq === (m_flg & m_ewe), "R8", "ewi_irq", {31'b0, ewi_irq},
                  {31'b0, m_flg & m_ewe});
            check(bus_rdata === exp_rd(bus_addr), rd_tag(bus_addr), "read-back",
                  {16'b0, bus_rdata}, {16'b0, exp_rd(bus_addr)});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: hung run, actual %0d cycles expected fewer", cyc);
            finish_up();
        end
    end

    task automatic do_reset();
        @(negedge clk); #1;
        rst_n = 1'b0; bus_we = 1'b0; dbg_halt = 1'b0; dbg_freeze_en = 1'b0;
        repeat (3) @(negedge clk);
        #1 rst_n = 1'b1;
        started = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] be, input logic [15:0] d);
        @(negedge clk); #1;
        bus_we = 1'b1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [15:0] d);
        @(negedge clk); #1;
        bus_addr = a;
        #0.5 d = bus_rdata;
    endtask

    task automatic timeout_run(input logic [1:0] sel, input int expect_n, input string tag);
        int n;
        do_reset();
        wr(2'd1, 2'b10, {5'b0, 1'b0, sel, 8'h00});
        wr(2'd0, 2'b01, 16'h00FF);
        n = 1;
        while (rst_req !== 1'b1 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        check(n == expect_n, tag, "negedges from load to reset pulse", n, expect_n);
        @(negedge clk);
        check(rst_req === 1'b0, "R10", "pulse width", {31'b0, rst_req}, 0);
    endtask

    initial begin
        logic [15:0] d;
        bit extra;
        void'($urandom(32'd20240611));

        // R1: reset state
        do_reset();
        rd(2'd0, d); check(d == 16'h007F, "R1", "control after reset", d, 16'h007F);
        rd(2'd1, d); check(d == 16'h007F, "R1", "config after reset", d, 16'h007F);
        rd(2'd2, d); check(d == 16'h0000, "R1", "status after reset", d, 0);
        check(rst_req === 1'b0 && ewi_irq === 1'b0, "R1", "outputs after reset",
              {30'b0, rst_req, ewi_irq}, 0);

        // R4 / R3: 64 ticks from 0x7F, at two prescaler settings
        timeout_run(2'd3, 64 * 16 + 1, "R4");
        extra = 1'b0;
        repeat (2100) begin
            @(negedge clk);
            if (rst_req) extra = 1'b1;
        end
        check(!extra, "R10", "no second reset request after wrap", {31'b0, extra}, 0);
        timeout_run(2'd1, 64 * 4 + 1, "R3");

        // R7: activate cannot be cleared; R6 boundary: count equal to window accepted
        do_reset();
        wr(2'd1, 2'b10, 16'h0300);
        wr(2'd0, 2'b01, 16'h00FF);
        wr(2'd0, 2'b01, 16'h007F);
        check(rst_req === 1'b0, "R6", "refresh at count == window", {31'b0, rst_req}, 0);
        rd(2'd0, d); check(d[7] == 1'b1, "R7", "activate after write of 0", d[7], 1);

        // R6: premature refresh one step above window
        do_reset();
        wr(2'd1, 2'b11, 16'h0350);
        wr(2'd0, 2'b01, 16'h00D1);
        check(rst_req === 1'b0, "R6", "first activation is not premature", {31'b0, rst_req}, 0);
        wr(2'd0, 2'b01, 16'h00FF);
        check(rst_req === 1'b1, "R6", "refresh above window", {31'b0, rst_req}, 1);
        rd(2'd0, d); check(d[6:0] == 7'h7F, "R6", "count loaded despite early refresh", d[6:0], 7'h7F);

        // R5: byte lanes of the configuration register
        do_reset();
        wr(2'd1, 2'b01, 16'h0755);
        rd(2'd1, d); check(d == 16'h0055, "R5", "lane 0 only", d, 16'h0055);
        wr(2'd1, 2'b10, 16'h0722);
        rd(2'd1, d); check(d == 16'h0755, "R5", "lane 1 only", d, 16'h0755);
        wr(2'd1, 2'b00, 16'h0000);
        rd(2'd1, d); check(d == 16'h0755, "R5", "no lanes", d, 16'h0755);

        // R8: early warning point, write-1 ignored, write-0 clears
        do_reset();
        wr(2'd1, 2'b11, 16'h047F);
        wr(2'd0, 2'b01, 16'h00C2);
        begin
            int n;
            n = 1;
            while (ewi_irq !== 1'b1 && n < 100) begin
                @(negedge clk);
                n++;
            end
            check(n == 5, "R8", "negedges from load of 0x42 to interrupt", n, 5);
        end
        wr(2'd2, 2'b01, 16'h0001);
        check(ewi_irq === 1'b1, "R8", "write of 1 keeps flag", {31'b0, ewi_irq}, 1);
        wr(2'd2, 2'b01, 16'h0000);
        check(ewi_irq === 1'b0, "R8", "write of 0 clears flag", {31'b0, ewi_irq}, 0);

        // R9: freeze only when both debug inputs are high
        do_reset();
        dbg_halt = 1'b1; dbg_freeze_en = 1'b1;
        wr(2'd0, 2'b01, 16'h00FF);
        repeat (50) @(negedge clk);
        rd(2'd0, d); check(d == 16'h00FF, "R9", "count frozen", d, 16'h00FF);
        #1 dbg_freeze_en = 1'b0;
        repeat (20) @(negedge clk);
        rd(2'd0, d); check(d[6:0] < 7'h7F, "R9", "halt alone does not freeze", d[6:0], 7'h7E);

        // Random phase checked against the model
        for (int seg = 0; seg < 30; seg++) begin
            do_reset();
            for (int i = 0; i < 300; i++) begin
                int unsigned r;
                @(negedge clk); #1;
                bus_we = 1'b0;
                r = $urandom % 64;
                bus_addr = 2'($urandom % 4);
                if (r == 0) begin
                    bus_we = 1'b1; bus_addr = 2'd0;
                    bus_be = ($urandom % 8 == 0) ? 2'b10 : 2'b01;
                    bus_wdata = {8'h00, 1'($urandom % 2), 7'(7'h3C + $urandom % 68)};
                end else if (r < 3) begin
                    bus_we = 1'b1; bus_addr = 2'd1; bus_be = 2'($urandom % 4);
                    bus_wdata = {5'b0, 3'($urandom % 8), 1'b0, 7'(7'h40 + $urandom % 64)};
                end else if (r == 3) begin
                    bus_we = 1'b1; bus_addr = 2'd2; bus_be = 2'($urandom % 4);
                    bus_wdata = 16'($urandom % 2);
                end else if (r == 4) begin
                    dbg_halt = ~dbg_halt;
                end else if (r == 5) begin
                    dbg_freeze_en = ~dbg_freeze_en;
                end
            end
            @(negedge clk); #1 bus_we = 1'b0;
        end

        @(negedge clk);
        finish_up();
    end
endmodule